// File: doc/BRIEF.md
# CAN Controller Operating-Mode Sequencer

This block holds the operating mode of a CAN protocol controller. Software places a 3-bit mode request on `req_mode_i`, and `mode_o` reports the mode that is actually in force. `mode_o` changes only when the block grants the request. A grant waits until no transmission is pending. Every mode other than normal also needs a quiet bus: 11 consecutive recessive samples, no frame in progress, and RX high.

From the current mode the block derives the transmit enable, the receive enable, the error-counter clear, the module clock enable and the configuration-write gate. Writes to protected configuration registers pass only while the block is in configuration mode. A staged functional-mode selection is copied to its active output at the moment configuration mode is left.

In disable mode the module clock enable is low. A recessive-to-dominant edge on RX then raises a wake flag, unless wake-up is masked. The same edge returns the block to the mode it held before disable. The transmit and receive enables stay low until the bus has been idle for 11 bits again, so the frame that caused the wake-up is dropped. While the request still asks for disable after a wake-up, that request is not honoured again. Software must write a different request first.

Top module: `can_mode_seq`

## Requirements
- R1: After reset `mode_o` reads 100 (configuration), `clk_en_o`=1, `wake_o`=0, `tx_en_o`=0, `rx_en_o`=0, `err_clr_o`=1 and `fsel_o`=0.
- R2: Request codes decode as 000 normal, 001 disable, 010 loopback, 011 listen-only, and any code with bit 2 set as configuration (status 100). `mode_o` shows the same code and changes only on the cycle the mode is entered, one clock after the grant conditions hold.
- R3: No mode change is granted while `tx_pend_i` is high.
- R4: Entry to any mode other than normal requires 11 consecutive recessive samples (`sample_i` high with `rx_i`=1), `bus_active_i` low and `rx_i` high. A dominant sample restarts the count. Normal mode needs only drained transmissions.
- R5: The request is taken as a level. A request that changes while pending replaces the earlier one.
- R6: `cfg_wr_ok_o` follows `cfg_wr_i` only in configuration mode. In other modes it stays low, and `fsel_wr_i` leaves the staged functional mode unchanged.
- R7: `fsel_o` takes the staged value only on the clock that leaves configuration mode, and holds it otherwise.
- R8: `tx_en_o` is high in normal and loopback. `rx_en_o` is high in normal, loopback and listen-only. `err_clr_o` is high only in configuration.
- R9: In disable mode `clk_en_o` is low and both data enables are low. With `wake_dis_i`=0, a falling RX edge sets `wake_o` on the next clock. With `wake_dis_i`=1 it has no effect.
- R10: A wake-up returns `mode_o` to the mode in force before disable on the same clock and restarts the idle count. The data enables stay low until 11 recessive samples have been seen. A still-present disable request is ignored until the request changes.
- R11: `wake_clr_i` clears `wake_o`. A simultaneous wake event wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_mode_i | input | 3 | Requested mode code |
| rx_i | input | 1 | CAN RX line (1 = recessive) |
| sample_i | input | 1 | Bit sample-point strobe |
| tx_pend_i | input | 1 | A message transmission is pending |
| bus_active_i | input | 1 | A frame is being sent or received |
| wake_dis_i | input | 1 | Masks bus-activity wake-up |
| wake_clr_i | input | 1 | Clears the wake flag |
| cfg_wr_i | input | 1 | Write strobe to protected configuration registers |
| fsel_wr_i | input | 1 | Write strobe for the staged functional mode |
| fsel_i | input | 2 | Staged functional-mode value |
| mode_o | output | 3 | Mode in force |
| cfg_wr_ok_o | output | 1 | Gated configuration write |
| fsel_o | output | 2 | Active functional mode |
| tx_en_o | output | 1 | Transmitter enable |
| rx_en_o | output | 1 | Receiver enable |
| err_clr_o | output | 1 | Holds error counters cleared |
| clk_en_o | output | 1 | Module clock enable |
| wake_o | output | 1 | Wake-up flag |

## Verification
A wrong mode register shows on `mode_o` and the four enables on the clock after the faulty grant. Tests therefore sample one cycle after each condition is met, and also one cycle before it is met. An idle counter that saturates or restarts wrongly moves the grant, or the release of the dropped frame, by at least one bit strobe. The tests check just below and exactly at 11 recessive bits. A lost record of the previous mode, or a missing disable block, appears on `mode_o` at the wake clock, or 11 bits later.

// File: rtl/can_mode_pkg.sv
package can_mode_pkg;
  localparam int MODE_W = 3;
  typedef enum logic [MODE_W-1:0] {
    MD_NORM   = 3'b000,
    MD_DIS    = 3'b001,
    MD_LOOP   = 3'b010,
    MD_LISTEN = 3'b011,
    MD_CFG    = 3'b100
  } mode_e;

  function automatic mode_e decode_req(input logic [MODE_W-1:0] req);
    if (req[MODE_W-1]) return MD_CFG;
    return mode_e'({1'b0, req[MODE_W-2:0]});
  endfunction
endpackage

// File: rtl/can_mode_idle_mon.sv
module can_mode_idle_mon #(
  parameter int IDLE_BITS = 11
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sample_i,
  input  logic rx_i,
  input  logic clr_i,
  output logic idle_o
);
  localparam int CW = $clog2(IDLE_BITS + 1);
  localparam logic [CW-1:0] CMAX = CW'(IDLE_BITS);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clr_i)             cnt_q <= '0;
    else if (sample_i) begin
      if (!rx_i)                cnt_q <= '0;
      else if (cnt_q != CMAX)   cnt_q <= cnt_q + CW'(1);
    end
  end

  assign idle_o = (cnt_q == CMAX);

  AST_IDLE_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CMAX); // R4
  AST_DOM_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_i && !rx_i) |=> !idle_o); // R4
endmodule

// File: rtl/can_mode_fsm.sv
module can_mode_fsm
  import can_mode_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [MODE_W-1:0] req_i,
  input  logic              tx_pend_i,
  input  logic              bus_active_i,
  input  logic              rx_i,
  input  logic              idle_i,
  input  logic              wake_dis_i,
  input  logic              wake_clr_i,
  output mode_e             mode_o,
  output logic              leave_cfg_o,
  output logic              wake_evt_o,
  output logic              wake_o,
  output logic              tx_en_o,
  output logic              rx_en_o,
  output logic              err_clr_o,
  output logic              clk_en_o
);
  mode_e mode_q, prev_q, target;
  logic  rx_q, drop_q, block_q, wake_q;
  logic  need_idle, cond_ok, grant;

  assign target     = decode_req(req_i);
  assign need_idle  = (target != MD_NORM);
  assign cond_ok    = !tx_pend_i &&
                      (!need_idle || (idle_i && !bus_active_i && rx_i));
  assign wake_evt_o = (mode_q == MD_DIS) && !wake_dis_i && rx_q && !rx_i;
  assign grant      = !wake_evt_o && (target != mode_q) && cond_ok &&
                      !(block_q && target == MD_DIS);
  assign leave_cfg_o = grant && (mode_q == MD_CFG);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= MD_CFG;
      prev_q  <= MD_CFG;
      rx_q    <= 1'b1;
      drop_q  <= 1'b0;
      block_q <= 1'b0;
      wake_q  <= 1'b0;
    end else begin
      rx_q <= rx_i;
      if (wake_evt_o) begin
        mode_q  <= prev_q;
        drop_q  <= 1'b1;
        block_q <= 1'b1;
      end else begin
        if (grant) begin
          mode_q <= target;
          if (target == MD_DIS) prev_q <= mode_q;
        end
        if (idle_i)              drop_q  <= 1'b0;
        if (target != MD_DIS)    block_q <= 1'b0;
      end
      if (wake_evt_o)      wake_q <= 1'b1;
      else if (wake_clr_i) wake_q <= 1'b0;
    end
  end

  assign mode_o    = mode_q;
  assign wake_o    = wake_q;
  assign tx_en_o   = !drop_q && (mode_q == MD_NORM || mode_q == MD_LOOP);
  assign rx_en_o   = !drop_q && (mode_q == MD_NORM || mode_q == MD_LOOP ||
                                 mode_q == MD_LISTEN);
  assign err_clr_o = (mode_q == MD_CFG);
  assign clk_en_o  = (mode_q != MD_DIS);

  AST_DRAIN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_pend_i && !wake_evt_o) |=> $stable(mode_q)); // R3
  AST_IDLE_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!idle_i && !wake_evt_o) |=> ($stable(mode_q) || mode_q == MD_NORM)); // R4
  AST_DIS_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MD_DIS) |-> (!tx_en_o && !rx_en_o && !clk_en_o)); // R9
  AST_WAKE_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wake_q) |-> $past(mode_q) == MD_DIS); // R9
  AST_WAKE_RESTORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_evt_o |=> (mode_q != MD_DIS && !tx_en_o && !rx_en_o)); // R10
endmodule

// File: rtl/can_mode_cfg_gate.sv
module can_mode_cfg_gate
  import can_mode_pkg::*;
#(
  parameter int FSEL_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  mode_e             mode_i,
  input  logic              leave_cfg_i,
  input  logic              cfg_wr_i,
  input  logic              fsel_wr_i,
  input  logic [FSEL_W-1:0] fsel_i,
  output logic              cfg_wr_ok_o,
  output logic [FSEL_W-1:0] fsel_o
);
  logic              in_cfg;
  logic [FSEL_W-1:0] stage_q, act_q;

  assign in_cfg = (mode_i == MD_CFG);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
      act_q   <= '0;
    end else begin
      if (fsel_wr_i && in_cfg) stage_q <= fsel_i;
      if (leave_cfg_i)         act_q   <= stage_q;
    end
  end

  assign cfg_wr_ok_o = cfg_wr_i && in_cfg;
  assign fsel_o      = act_q;

  AST_CFG_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_wr_ok_o |-> mode_i == MD_CFG); // R6
  AST_FSEL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MD_CFG) |=> (mode_i != MD_CFG || $stable(fsel_o))); // R7
endmodule

// File: rtl/can_mode_seq.sv
module can_mode_seq
  import can_mode_pkg::*;
#(
  parameter int IDLE_BITS = 11,
  parameter int FSEL_W    = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [MODE_W-1:0] req_mode_i,
  input  logic              rx_i,
  input  logic              sample_i,
  input  logic              tx_pend_i,
  input  logic              bus_active_i,
  input  logic              wake_dis_i,
  input  logic              wake_clr_i,
  input  logic              cfg_wr_i,
  input  logic              fsel_wr_i,
  input  logic [FSEL_W-1:0] fsel_i,
  output logic [MODE_W-1:0] mode_o,
  output logic              cfg_wr_ok_o,
  output logic [FSEL_W-1:0] fsel_o,
  output logic              tx_en_o,
  output logic              rx_en_o,
  output logic              err_clr_o,
  output logic              clk_en_o,
  output logic              wake_o
);
  mode_e mode;
  logic  idle, wake_evt, leave_cfg;

  can_mode_idle_mon #(.IDLE_BITS(IDLE_BITS)) u_idle (
    .clk_i, .rst_ni, .sample_i, .rx_i,
    .clr_i (wake_evt),
    .idle_o(idle)
  );

  can_mode_fsm u_fsm (
    .clk_i, .rst_ni,
    .req_i       (req_mode_i),
    .tx_pend_i, .bus_active_i, .rx_i,
    .idle_i      (idle),
    .wake_dis_i, .wake_clr_i,
    .mode_o      (mode),
    .leave_cfg_o (leave_cfg),
    .wake_evt_o  (wake_evt),
    .wake_o, .tx_en_o, .rx_en_o, .err_clr_o, .clk_en_o
  );

  can_mode_cfg_gate #(.FSEL_W(FSEL_W)) u_gate (
    .clk_i, .rst_ni,
    .mode_i      (mode),
    .leave_cfg_i (leave_cfg),
    .cfg_wr_i, .fsel_wr_i, .fsel_i,
    .cfg_wr_ok_o, .fsel_o
  );

  assign mode_o = mode;
endmodule

// File: tb/can_mode_seq_test.sv
module can_mode_seq_test;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic [2:0] req = 3'b100;
  logic       rx = 1'b1, smp = 1'b0, txp = 1'b0, busy = 1'b0;
  logic       wdis = 1'b0, wclr = 1'b0, cwr = 1'b0, fwr = 1'b0;
  logic [1:0] fsel = 2'd0;
  logic [2:0] mode;
  logic       cfg_ok, tx_en, rx_en, err_clr, clk_en, wake;
  logic [1:0] fsel_act;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  can_mode_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .req_mode_i(req), .rx_i(rx), .sample_i(smp),
    .tx_pend_i(txp), .bus_active_i(busy), .wake_dis_i(wdis), .wake_clr_i(wclr),
    .cfg_wr_i(cwr), .fsel_wr_i(fwr), .fsel_i(fsel),
    .mode_o(mode), .cfg_wr_ok_o(cfg_ok), .fsel_o(fsel_act), .tx_en_o(tx_en),
    .rx_en_o(rx_en), .err_clr_o(err_clr), .clk_en_o(clk_en), .wake_o(wake)
  );

  task automatic chk(input string req_tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req_tag, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic send_bit(input logic v);
    rx = v; smp = 1'b1; tick(); smp = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1", "mode", mode, 3'b100);
    chk("R1", "clk_en", clk_en, 1);
    chk("R1", "wake", wake, 0);
    chk("R1", "tx_en", tx_en, 0);
    chk("R1", "rx_en", rx_en, 0);
    chk("R1", "err_clr", err_clr, 1);
    chk("R1", "fsel", fsel_act, 0);
  endtask

  task automatic t_cfg_stage();
    cwr = 1'b1; #1;
    chk("R6", "cfg_wr_ok in config", cfg_ok, 1);
    cwr = 1'b0;
    fsel = 2'd2; fwr = 1'b1; tick(); fwr = 1'b0;
    chk("R7", "fsel held in config", fsel_act, 0);
  endtask

  task automatic t_enter_normal();
    req = 3'b000; tick();
    chk("R2", "mode normal", mode, 3'b000);
    chk("R7", "fsel applied on leave", fsel_act, 2);
    chk("R8", "tx_en normal", tx_en, 1);
    chk("R8", "rx_en normal", rx_en, 1);
    chk("R8", "err_clr normal", err_clr, 0);
    cwr = 1'b1; #1;
    chk("R6", "cfg_wr_ok locked", cfg_ok, 0);
    cwr = 1'b0;
    fsel = 2'd1; fwr = 1'b1; tick(); fwr = 1'b0;
  endtask

  task automatic t_drain();
    txp = 1'b1; req = 3'b100;
    for (int i = 0; i < 12; i++) send_bit(1'b1);
    tick();
    chk("R3", "held while tx pending", mode, 3'b000);
    txp = 1'b0; tick();
    chk("R3", "config after drain", mode, 3'b100);
    req = 3'b000; tick();
    chk("R6", "staged fsel not written outside config", fsel_act, 2);
  endtask

  task automatic t_replace();
    busy = 1'b1; req = 3'b011; tick(); tick();
    chk("R4", "held while bus active", mode, 3'b000);
    req = 3'b010; tick();
    busy = 1'b0; tick();
    chk("R5", "latest request wins", mode, 3'b010);
    chk("R8", "tx_en loopback", tx_en, 1);
    chk("R8", "rx_en loopback", rx_en, 1);
    req = 3'b011; tick();
    chk("R2", "mode listen", mode, 3'b011);
    chk("R8", "tx_en listen", tx_en, 0);
    chk("R8", "rx_en listen", rx_en, 1);
  endtask

  task automatic t_idle_count();
    req = 3'b001;
    send_bit(1'b0);
    rx = 1'b1;
    for (int i = 0; i < 10; i++) send_bit(1'b1);
    tick();
    chk("R4", "10 recessive not enough", mode, 3'b011);
    send_bit(1'b1);
    tick();
    chk("R4", "disable after 11 recessive", mode, 3'b001);
    chk("R9", "clk_en disable", clk_en, 0);
    chk("R9", "tx_en disable", tx_en, 0);
    chk("R9", "rx_en disable", rx_en, 0);
  endtask

  task automatic t_wake_masked();
    wdis = 1'b1; rx = 1'b0; tick();
    chk("R9", "masked edge no wake", wake, 0);
    chk("R9", "masked edge stays disabled", mode, 3'b001);
    rx = 1'b1; tick();
    wdis = 1'b0;
  endtask

  task automatic t_wake();
    rx = 1'b0; tick();
    chk("R9", "wake flag set", wake, 1);
    chk("R10", "previous mode restored", mode, 3'b011);
    chk("R10", "rx_en dropped", rx_en, 0);
    rx = 1'b1;
    for (int i = 0; i < 10; i++) send_bit(1'b1);
    tick();
    chk("R10", "frame still dropped at 10 bits", rx_en, 0);
    send_bit(1'b1);
    tick();
    chk("R10", "rx_en back after 11 bits", rx_en, 1);
    chk("R10", "stale disable request ignored", mode, 3'b011);
  endtask

  task automatic t_wake_clr();
    wclr = 1'b1; tick(); wclr = 1'b0;
    chk("R11", "wake cleared", wake, 0);
  endtask

  task automatic t_cfg_code();
    req = 3'b110; tick();
    chk("R2", "code 110 -> config", mode, 3'b100);
    chk("R8", "err_clr config", err_clr, 1);
    chk("R8", "rx_en config", rx_en, 0);
  endtask

  initial begin
    #(20 * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cfg_stage();
    t_enter_normal();
    t_drain();
    t_replace();
    t_idle_count();
    t_wake_masked();
    t_wake();
    t_wake_clr();
    t_cfg_code();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule